// File: doc/BRIEF.md
# Six-Level Thermometer March Self-Test Engine

This engine runs a self-test over a memory array whose cells store one of six analog levels. Each level moves across the memory port as a 5-digit thermometer code, from 00000 up to 11111. The test does not flip cells between two values. It lifts every cell one level per pass. The first pass clears the whole array. Each middle pass reads back the level the previous pass left and then writes the next level up. The last pass only reads, and checks that every cell holds the top code.

All passes visit the addresses from low to high and issue one memory operation per clock. A middle pass does its read and then its write to the same address on the next cycle. The memory returns read data one cycle after the read. The engine compares the data in that cycle. The first mismatch sets a fail flag that stays set, and it records the address, the pass number, the expected code and the code that came back. The test keeps running to the end in either case. A host pulses `start` and waits for `done`, then reads the fail flag and the record.

Top module: `mlmarch_bist`

## Requirements
- R1: While reset is high and after it is released, and until `start` is accepted, `mem_en`, `done`, `fail` and all `fail_*` outputs are 0.
- R2: Pass 0 begins on the cycle after `start` is accepted. It writes 00000 to each address, one write per cycle, from address 0 up to the top address.
- R3: Passes 1 to 5 each visit every address in ascending order. At each address the pass issues a read that expects the code with (pass−1) low-order ones. On the next cycle it writes the code with (pass) low-order ones to the same address. Every written value is a thermometer code.
- R4: Pass 6 reads every address in ascending order and expects 11111. It issues no writes.
- R5: A run issues exactly 12 operations per address (6 writes, 6 reads) on consecutive cycles, with no idle cycles between them.
- R6: The engine compares `mem_rdata` in the cycle after the matching read. A mismatch raises `fail` one cycle later.
- R7: The first mismatch captures the read address, the pass number (0 to 6), the expected code and the code read. `fail` stays high. Later mismatches do not change the record.
- R8: A run continues after a failure. `done` rises two cycles after the last operation and stays high, with `mem_en` at 0, until the next accepted start.
- R9: A `start` pulse while a run is in progress is ignored. The operation sequence and the `done` timing are unchanged.
- R10: A `start` accepted while idle or done clears `fail`, the record and `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| mem_en | output | 1 | Memory operation valid this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | CODE_W | Thermometer code to write |
| mem_rdata | input | CODE_W | Read data, valid one cycle after a read |
| done | output | 1 | Run complete |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of first mismatch |
| fail_elem | output | ELEM_W | Pass number of first mismatch |
| fail_exp | output | CODE_W | Expected code at first mismatch |
| fail_got | output | CODE_W | Code read at first mismatch |

## Verification
A broken address or pass counter shows up on the memory port in the very operation it corrupts. The bench rebuilds the complete expected sequence of operations arithmetically and compares it cycle by cycle. A stuck cell on the bench-side memory model is swept over every address, every digit and both polarities. A wrong expected code or a misaligned compare therefore yields a wrong failure record at `done`, about 12 cycles per address after start. A fault in the end-of-run logic shows as an operation count or `done` timing that is off by at least one cycle.

// File: rtl/mlm_pkg.sv
package mlm_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_RUN   = 2'd1,
        SQ_FLUSH = 2'd2,
        SQ_DONE  = 2'd3
    } sq_state_e;

    typedef enum logic {
        PH_READ  = 1'b0,
        PH_WRITE = 1'b1
    } op_phase_e;

    // Next level: shift a one in at the least significant digit.
    function automatic logic [31:0] thermo_raise(input logic [31:0] c);
        return {c[30:0], 1'b1};
    endfunction

    // One clearing pass, one pass per raise, one final check pass.
    function automatic int unsigned pass_count(input int unsigned code_w);
        return code_w + 2;
    endfunction

endpackage

// File: rtl/mlm_seq.sv
module mlm_seq
    import mlm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CODE_W = 5,
    parameter int ELEM_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CODE_W-1:0] mem_wdata,
    output logic [CODE_W-1:0] op_exp,
    output logic [ELEM_W-1:0] op_elem,
    output logic              clr_log,
    output logic              done
);
    localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(pass_count(CODE_W) - 1);
    localparam logic [ADDR_W-1:0] TOP_ADDR  = {ADDR_W{1'b1}};

    sq_state_e         state;
    op_phase_e         phase;
    logic [ELEM_W-1:0] elem;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] cur_code;
    logic [CODE_W-1:0] next_code;
    logic              has_rd;
    logic              has_wr;
    logic              accept;

    always_comb begin
        has_rd    = (elem != '0);
        has_wr    = (elem != LAST_ELEM);
        next_code = CODE_W'(thermo_raise(32'(cur_code)));
        accept    = start && (state == SQ_IDLE || state == SQ_DONE);
        mem_en    = (state == SQ_RUN);
        mem_we    = mem_en && (phase == PH_WRITE);
        mem_addr  = addr;
        mem_wdata = (elem == '0) ? '0 : next_code;
        op_exp    = cur_code;
        op_elem   = elem;
        clr_log   = accept;
        done      = (state == SQ_DONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            phase    <= PH_WRITE;
            elem     <= '0;
            addr     <= '0;
            cur_code <= '0;
        end else begin
            case (state)
                SQ_IDLE, SQ_DONE: begin
                    if (accept) begin
                        state    <= SQ_RUN;
                        phase    <= PH_WRITE;
                        elem     <= '0;
                        addr     <= '0;
                        cur_code <= '0;
                    end
                end
                SQ_RUN: begin
                    if (phase == PH_READ && has_wr) begin
                        phase <= PH_WRITE;
                    end else if (addr == TOP_ADDR) begin
                        addr <= '0;
                        if (elem == LAST_ELEM) begin
                            state <= SQ_FLUSH;
                        end else begin
                            elem  <= elem + 1'b1;
                            phase <= PH_READ;
                            if (has_rd) cur_code <= next_code;
                        end
                    end else begin
                        addr  <= addr + 1'b1;
                        phase <= has_rd ? PH_READ : PH_WRITE;
                    end
                end
                SQ_FLUSH: state <= SQ_DONE;
                default:  state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mlm_log.sv
module mlm_log #(
    parameter int ADDR_W = 4,
    parameter int CODE_W = 5,
    parameter int ELEM_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              rd_issue,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ELEM_W-1:0] rd_elem,
    input  logic [CODE_W-1:0] rd_exp,
    input  logic [CODE_W-1:0] mem_rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ELEM_W-1:0] fail_elem,
    output logic [CODE_W-1:0] fail_exp,
    output logic [CODE_W-1:0] fail_got
);
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [ELEM_W-1:0] elem;
        logic [CODE_W-1:0] exp;
    } pend_t;

    pend_t pend;
    logic  mismatch;

    assign mismatch = pend.vld && (mem_rdata != pend.exp);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend      <= '0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
            fail_exp  <= '0;
            fail_got  <= '0;
        end else begin
            pend <= '{vld: rd_issue, addr: rd_addr, elem: rd_elem, exp: rd_exp};
            if (mismatch && !fail) begin
                fail      <= 1'b1;
                fail_addr <= pend.addr;
                fail_elem <= pend.elem;
                fail_exp  <= pend.exp;
                fail_got  <= mem_rdata;
            end
        end
    end

endmodule

// File: rtl/mlmarch_bist.sv
module mlmarch_bist
    import mlm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CODE_W = 5,
    parameter int ELEM_W = $clog2(CODE_W + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CODE_W-1:0] mem_wdata,
    input  logic [CODE_W-1:0] mem_rdata,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ELEM_W-1:0] fail_elem,
    output logic [CODE_W-1:0] fail_exp,
    output logic [CODE_W-1:0] fail_got
);
    logic [CODE_W-1:0] op_exp;
    logic [ELEM_W-1:0] op_elem;
    logic              clr_log;

    mlm_seq #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .ELEM_W(ELEM_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .op_exp    (op_exp),
        .op_elem   (op_elem),
        .clr_log   (clr_log),
        .done      (done)
    );

    mlm_log #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .ELEM_W(ELEM_W)) u_log (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr_log),
        .rd_issue  (mem_en && !mem_we),
        .rd_addr   (mem_addr),
        .rd_elem   (op_elem),
        .rd_exp    (op_exp),
        .mem_rdata (mem_rdata),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_elem (fail_elem),
        .fail_exp  (fail_exp),
        .fail_got  (fail_got)
    );

endmodule

// File: rtl/mlm_march_chk.sv
module mlm_march_chk #(
    parameter int ADDR_W = 4,
    parameter int CODE_W = 5,
    parameter int ELEM_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CODE_W-1:0] mem_wdata,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [ELEM_W-1:0] fail_elem,
    input logic [CODE_W-1:0] fail_exp,
    input logic [CODE_W-1:0] fail_got
);
    assert_thermo_write_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we) |-> ((mem_wdata & (mem_wdata + 1'b1)) == '0));

    assert_rmw_same_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_en && mem_we && $past(mem_en && !mem_we)) |-> (mem_addr == $past(mem_addr)));

    assert_first_op_clear_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_en) |-> (mem_we && mem_addr == '0 && mem_wdata == '0));

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_en);

    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> fail);

    assert_log_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> ($stable(fail_addr) && $stable(fail_elem)
                              && $stable(fail_exp) && $stable(fail_got)));

    assert_fail_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> $past(mem_en && !mem_we, 2));

endmodule

bind mlmarch_bist mlm_march_chk #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .ELEM_W(ELEM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .fail_elem (fail_elem),
    .fail_exp  (fail_exp),
    .fail_got  (fail_got)
);

// File: tb/tb_mlmarch_bist.sv
module tb_mlmarch_bist;
    localparam int AW    = 4;
    localparam int CW    = 5;
    localparam int EW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int NOPS  = 12 * DEPTH;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          mem_en, mem_we, done, fail;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [CW-1:0] mem_wdata, mem_rdata, fail_exp, fail_got;
    logic [EW-1:0] fail_elem;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Stuck-cell faults in the memory model (two independent slots).
    bit f0_on = 0, f1_on = 0;
    int f0_addr, f0_bit, f0_val, f1_addr, f1_bit, f1_val;

    always #2.5 clk = ~clk;

    mlmarch_bist #(.ADDR_W(AW), .CODE_W(CW)) dut (
        .clk(clk), .rst(rst), .start(start),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .fail(fail), .fail_addr(fail_addr),
        .fail_elem(fail_elem), .fail_exp(fail_exp), .fail_got(fail_got)
    );

    logic [CW-1:0] mem [DEPTH];

    function automatic logic [CW-1:0] stick(input logic [CW-1:0] d, input int a);
        logic [CW-1:0] r = d;
        if (f0_on && a == f0_addr) r[f0_bit] = f0_val[0];
        if (f1_on && a == f1_addr) r[f1_bit] = f1_val[0];
        return r;
    endfunction

    always @(posedge clk) begin
        if (mem_en && mem_we)  mem[mem_addr] <= stick(mem_wdata, int'(mem_addr));
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
    end

    function automatic logic [CW-1:0] level(input int n);
        return CW'((1 << n) - 1);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected operation number n of a run: write flag, address, write data.
    task automatic exp_op(input int n, output bit we, output int a, output int d);
        int m;
        d = 0;
        if (n < DEPTH) begin
            we = 1; a = n; d = 0;
        end else if (n < 11 * DEPTH) begin
            m  = n - DEPTH;
            a  = (m % (2 * DEPTH)) / 2;
            we = (m % 2) == 1;
            d  = we ? int'(level(1 + m / (2 * DEPTH))) : 0;
        end else begin
            we = 0; a = n - 11 * DEPTH;
        end
    endtask

    task automatic run_test(input int glitch_cyc, input string tag);
        int  n = 0;
        int  cyc = 0;
        bit  bad = 0;
        int  bad_n = 0, bad_act = 0, bad_exp = 0;
        bit  ewe;
        int  ea, ed;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        // R10: accepted start clears the previous outcome
        check(!done && !fail && fail_addr == 0 && fail_got == 0, "R10",
              {tag, " clear on start"}, int'({done, fail}), 0);
        while (!done && cyc < NOPS + 10) begin
            if (mem_en) begin
                exp_op(n, ewe, ea, ed);
                if (!bad && (mem_we != ewe || int'(mem_addr) != ea || (ewe && int'(mem_wdata) != ed))) begin
                    bad = 1; bad_n = n;
                    bad_act = int'({mem_we, mem_addr, mem_wdata});
                    bad_exp = (int'(ewe) << (AW + CW)) | (ea << CW) | ed;
                end
                n++;
            end
            start = (cyc == glitch_cyc);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        // R2 R3 R4 R9: every operation matches the arithmetic schedule
        check(!bad, "R3", $sformatf("%s op %0d {we,addr,data}", tag, bad_n), bad_act, bad_exp);
        check(n == NOPS, "R5", {tag, " operation count"}, n, NOPS);
        check(done && cyc == NOPS + 1, "R8", {tag, " done timing"}, cyc, NOPS + 1);
        repeat (3) @(negedge clk);
        check(done && !mem_en, "R8", {tag, " done held"}, int'({done, mem_en}), 2);
    endtask

    task automatic expect_log(input bit f, input int a, input int e, input int x, input int g,
                              input string tag);
        check(fail == f, "R7", {tag, " fail flag"}, int'(fail), int'(f));
        if (f) begin
            check(int'(fail_addr) == a && int'(fail_elem) == e, "R7",
                  {tag, " addr*8+elem"}, int'(fail_addr) * 8 + int'(fail_elem), a * 8 + e);
            check(int'(fail_exp) == x && int'(fail_got) == g, "R6",
                  {tag, " exp*32+got"}, int'(fail_exp) * 32 + int'(fail_got), x * 32 + g);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!mem_en && !done && !fail && fail_addr == 0 && fail_elem == 0
              && fail_exp == 0 && fail_got == 0, "R1", "during reset",
              int'({mem_en, done, fail}), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check(!mem_en && !done && !fail, "R1", "idle after reset", int'({mem_en, done, fail}), 0);

        // Clean run
        run_test(-1, "clean");
        expect_log(0, 0, 0, 0, 0, "clean");

        // R9: start pulsed mid-run
        run_test(40, "glitch");
        expect_log(0, 0, 0, 0, 0, "glitch");

        // Sweep single stuck cells: every address, digit, polarity
        for (int a = 0; a < DEPTH; a++) begin
            for (int k = 0; k < CW; k++) begin
                for (int v = 0; v < 2; v++) begin
                    string t = $sformatf("sweep a%0d b%0d sa%0d", a, k, v);
                    f0_on = 1; f0_addr = a; f0_bit = k; f0_val = v;
                    run_test(-1, t);
                    // R7: stuck-1 trips pass 1; stuck-0 at digit k trips pass k+2
                    if (v == 1)
                        expect_log(1, a, 1, 0, 1 << k, t);
                    else
                        expect_log(1, a, k + 2, int'(level(k + 1)),
                                   int'(level(k + 1)) & ~(1 << k), t);
                end
            end
        end

        // R7: two faults, earlier-in-time one wins even at higher address
        f0_on = 1; f0_addr = 9; f0_bit = 0; f0_val = 1;
        f1_on = 1; f1_addr = 2; f1_bit = 4; f1_val = 0;
        run_test(-1, "two faults");
        expect_log(1, 9, 1, 0, 1, "two faults");

        // R10: restart after failure on clean memory clears the flag
        f0_on = 0; f1_on = 0;
        run_test(-1, "rerun");
        expect_log(0, 0, 0, 0, 0, "rerun");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule